// File: doc/BRIEF.md
# Double-Buffered Fine-Resolution PWM Generator

This block produces a single pulse-width-modulated output from an 8-bit period timer. A 2-bit sub-count sits below the timer, so the timer and sub-count together form a 10-bit position that the 10-bit duty value is compared against. The position advances one step every P clocks, where P is the prescale ratio (1, 4 or 16) chosen through a register field. The timer counts from zero up to the period register value. When it reaches that value a new cycle begins: the output goes high, the written duty is copied into a shadow register, and a one-clock cycle-start pulse is raised.

Software loads a period, a duty and a prescale ratio through a small register write port, then raises `enable`. A duty written in the middle of a cycle is held in the write-side registers. It reaches the comparator only at the next cycle boundary, so a cycle can never be cut short or stretched by a late write. The cycle-start pulse is meant to drive an interrupt flag.

Top module: `fpwm_top`

## Requirements
- R1: After reset, `pwm_out` and `period_pulse` are low, the duty is 0, the prescale ratio is 1 and the period register holds 0xFF, so a cycle lasts 1024 clocks.
- R2: A write with `wr_en` high stores `wr_data` according to `wr_addr`. Address 0 loads the period. Address 1 loads duty bits 9:2. Address 2 loads duty bits 1:0 from `wr_data[5:4]`. Address 3 loads the prescale code from `wr_data[1:0]`: 00 selects 1, 01 selects 4, 10 and 11 select 16.
- R3: While enabled, the 10-bit position {timer, sub-count} advances by one every P clocks, and a cycle lasts 4*P*(period+1) clocks.
- R4: The output goes high only at a cycle start. It goes low once the position equals the active duty D, so it stays high for exactly D*P clocks.
- R5: An active duty of 0 keeps the output low for the whole cycle.
- R6: An active duty of 4*(period+1) or more never matches the position, so the output stays high for the whole cycle.
- R7: A duty written during a cycle does not affect that cycle. It takes effect from the next cycle start.
- R8: `period_pulse` is high for exactly one clock at every cycle start, in the clock where the timer and sub-count are both zero.
- R9: While `enable` is low, the timer and sub-count are held at zero and `pwm_out` and `period_pulse` are low. After `enable` rises, the output stays low until the first cycle start.
- R10: With period 0xFF every duty step from 1 to 1023 is distinct: a duty of 1 gives 1 high clock and 1023 gives 1023 high clocks at ratio 1. With period 0x3F a cycle is 256 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs the timer when high; holds the timer and output idle when low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select (see R2) |
| wr_data | input | 8 | Write data |
| pwm_out | output | 1 | Modulated output |
| period_pulse | output | 1 | One-clock pulse at each cycle start |

## Verification
The in-RTL assertions check on every cycle that the shadow duty changes only at a cycle boundary and that the output rises only together with the cycle-start pulse. They also check that this pulse lasts one clock and lands on position zero, that a zero shadow duty keeps the output low, and that disabling clears the output and the counters. High-time lengths, cycle lengths for each prescale ratio, duties beyond the period, and the effect of a mid-cycle duty write can only be shown by the bench. It compares the outputs with a behavioural model on every clock and measures whole cycles.

// File: rtl/fpwm_pkg.sv
package fpwm_pkg;

   typedef enum logic [1:0] {
      ADDR_PERIOD    = 2'd0,
      ADDR_DUTY_HI   = 2'd1,
      ADDR_DUTY_CTL  = 2'd2,
      ADDR_TIMER_CTL = 2'd3
   } fpwm_addr_e;

   // bit position of the low duty bits inside the duty control write
   localparam int DUTY_LO_LSB = 4;
   // prescale code field inside the timer control write
   localparam int PS_CODE_LSB = 0;
   localparam int PS_CODE_W   = 2;

   // map the prescale code onto an option index, saturating at the last option
   function automatic int ps_index(input logic [PS_CODE_W-1:0] code, input int n_opt);
      int c;
      c = int'(code);
      return (c >= n_opt - 1) ? (n_opt - 1) : c;
   endfunction

endpackage

// File: rtl/fpwm_regs.sv
module fpwm_regs #(
   parameter int TMR_W = 8,
   parameter int SUB_W = 2,
   localparam int POS_W = TMR_W + SUB_W
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic [1:0]                     wr_addr,
   input  logic [TMR_W-1:0]               wr_data,
   output logic [TMR_W-1:0]               period_o,
   output logic [POS_W-1:0]               duty_o,
   output logic [fpwm_pkg::PS_CODE_W-1:0] ps_code_o
);
   import fpwm_pkg::*;

   logic [TMR_W-1:0]     duty_hi_q;
   logic [SUB_W-1:0]     duty_lo_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         period_o  <= '1;
         duty_hi_q <= '0;
         duty_lo_q <= '0;
         ps_code_o <= '0;
      end else if (wr_en) begin
         case (fpwm_addr_e'(wr_addr))
            ADDR_PERIOD:    period_o  <= wr_data;
            ADDR_DUTY_HI:   duty_hi_q <= wr_data;
            ADDR_DUTY_CTL:  duty_lo_q <= wr_data[DUTY_LO_LSB +: SUB_W];
            ADDR_TIMER_CTL: ps_code_o <= wr_data[PS_CODE_LSB +: PS_CODE_W];
            default:        ;
         endcase
      end
   end

   assign duty_o = {duty_hi_q, duty_lo_q};

endmodule

// File: rtl/fpwm_timebase.sv
module fpwm_timebase #(
   parameter int TMR_W   = 8,
   parameter int SUB_W   = 2,
   parameter int PS_STEP = 2,
   parameter int N_PS    = 3,
   localparam int POS_W  = TMR_W + SUB_W,
   localparam int DIV_W  = SUB_W + PS_STEP * (N_PS - 1),
   localparam int K_W    = (N_PS > 1) ? $clog2(N_PS) : 1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           run,
   input  logic [fpwm_pkg::PS_CODE_W-1:0] ps_code,
   input  logic [TMR_W-1:0]               period,
   output logic [POS_W-1:0]               pos_o,
   output logic [POS_W-1:0]               nxt_pos_o,
   output logic                           rollover_o
);
   logic [DIV_W-1:0] div_q, div_n;
   logic [TMR_W-1:0] tmr_q, tmr_n;
   logic [DIV_W-1:0] lim_opt  [N_PS];
   logic [SUB_W-1:0] sub_opt  [N_PS];
   logic [SUB_W-1:0] nsub_opt [N_PS];
   logic [K_W-1:0]   k;
   logic             wrap, at_top;

   // one option per prescale ratio: the divider limit and the slice used as sub-count
   for (genvar g = 0; g < N_PS; g++) begin : g_ps
      localparam int SH = PS_STEP * g;
      assign lim_opt[g]  = DIV_W'((64'd1 << (SUB_W + SH)) - 64'd1);
      assign sub_opt[g]  = div_q[SH +: SUB_W];
      assign nsub_opt[g] = div_n[SH +: SUB_W];
   end

   always_comb k = K_W'(fpwm_pkg::ps_index(ps_code, N_PS));

   assign wrap   = (div_q >= lim_opt[k]);
   assign at_top = (tmr_q == period);

   always_comb begin
      if (!run) begin
         div_n = '0;
         tmr_n = '0;
      end else if (wrap) begin
         div_n = '0;
         tmr_n = at_top ? '0 : tmr_q + 1'b1;
      end else begin
         div_n = div_q + 1'b1;
         tmr_n = tmr_q;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_q <= '0;
         tmr_q <= '0;
      end else begin
         div_q <= div_n;
         tmr_q <= tmr_n;
      end
   end

   assign rollover_o = run && wrap && at_top;
   assign pos_o      = {tmr_q, sub_opt[k]};
   assign nxt_pos_o  = {tmr_n, nsub_opt[k]};

   assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (tmr_q == '0) && (div_q == '0))
      else $error("timebase not held at zero while idle");

endmodule

// File: rtl/fpwm_outstage.sv
module fpwm_outstage #(
   parameter int POS_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             rollover,
   input  logic [POS_W-1:0] duty_wr,
   input  logic [POS_W-1:0] nxt_pos,
   output logic             pwm_o,
   output logic             pulse_o
);
   logic [POS_W-1:0] shadow_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shadow_q <= '0;
         pwm_o    <= 1'b0;
         pulse_o  <= 1'b0;
      end else if (!run) begin
         pwm_o    <= 1'b0;
         pulse_o  <= 1'b0;
      end else if (rollover) begin
         shadow_q <= duty_wr;
         pwm_o    <= |duty_wr;
         pulse_o  <= 1'b1;
      end else begin
         pulse_o  <= 1'b0;
         if (nxt_pos == shadow_q) pwm_o <= 1'b0;
      end
   end

   assert_shadow_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !rollover |=> $stable(shadow_q))
      else $error("shadow duty changed away from a cycle boundary");

   assert_zero_duty_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (shadow_q == '0) |-> !pwm_o)
      else $error("output high with zero active duty");

   assert_disabled_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !pwm_o && !pulse_o)
      else $error("output active while disabled");

endmodule

// File: rtl/fpwm_top.sv
module fpwm_top #(
   parameter int TMR_W   = 8,
   parameter int SUB_W   = 2,
   parameter int PS_STEP = 2,
   parameter int N_PS    = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [TMR_W-1:0] wr_data,
   output logic             pwm_out,
   output logic             period_pulse
);
   localparam int POS_W = TMR_W + SUB_W;

   if (SUB_W < 1) begin : g_bad_sub
      $error("SUB_W must be at least 1");
   end
   if (TMR_W < fpwm_pkg::DUTY_LO_LSB + SUB_W) begin : g_bad_tmr
      $error("TMR_W too narrow to carry the low duty field");
   end
   if (PS_STEP < 1 || N_PS < 1 || N_PS > (1 << fpwm_pkg::PS_CODE_W)) begin : g_bad_ps
      $error("prescale option parameters out of range");
   end

   logic [TMR_W-1:0]               period;
   logic [POS_W-1:0]               duty_wr;
   logic [fpwm_pkg::PS_CODE_W-1:0] ps_code;
   logic [POS_W-1:0]               pos, nxt_pos;
   logic                           rollover;

   fpwm_regs #(.TMR_W(TMR_W), .SUB_W(SUB_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .period_o  (period),
      .duty_o    (duty_wr),
      .ps_code_o (ps_code)
   );

   fpwm_timebase #(.TMR_W(TMR_W), .SUB_W(SUB_W), .PS_STEP(PS_STEP), .N_PS(N_PS)) u_tb (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (enable),
      .ps_code    (ps_code),
      .period     (period),
      .pos_o      (pos),
      .nxt_pos_o  (nxt_pos),
      .rollover_o (rollover)
   );

   fpwm_outstage #(.POS_W(POS_W)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (enable),
      .rollover (rollover),
      .duty_wr  (duty_wr),
      .nxt_pos  (nxt_pos),
      .pwm_o    (pwm_out),
      .pulse_o  (period_pulse)
   );

   assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      period_pulse |=> !period_pulse)
      else $error("cycle-start pulse longer than one clock");

   assert_pulse_origin_R8: assert property (@(posedge clk) disable iff (!rst_n)
      period_pulse |-> (pos == '0))
      else $error("cycle-start pulse away from position zero");

   assert_rise_at_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwm_out) |-> period_pulse)
      else $error("output rose away from a cycle start");

endmodule

// File: tb/fpwm_top_bench.sv
module fpwm_top_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       enable = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       pwm_out, period_pulse;

   int n_cmp = 0;
   int n_bad = 0;
   string cur_req = "R1";
   bit done = 1'b0;

   always #4 clk = ~clk;

   fpwm_top u_fpwm_top (
      .clk(clk), .rst_n(rst_n), .enable(enable), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data),
      .pwm_out(pwm_out), .period_pulse(period_pulse)
   );

   // behavioural reference: position counted as an integer over the whole cycle
   int m_period = 255, m_duty = 0, m_ps = 0;
   int m_cnt = 0, m_fine = 0, m_shadow = 0;
   bit m_pwm = 0, m_pulse = 0;

   always @(posedge clk) begin
      int ratio;
      if (!rst_n) begin
         m_period = 255; m_duty = 0; m_ps = 0;
         m_cnt = 0; m_fine = 0; m_shadow = 0; m_pwm = 0; m_pulse = 0;
      end else begin
         ratio = (m_ps == 0) ? 1 : (m_ps == 1) ? 4 : 16;
         if (!enable) begin
            m_cnt = 0; m_fine = 0; m_pwm = 0; m_pulse = 0;
         end else begin
            m_pulse = 0;
            m_cnt++;
            if (m_cnt == ratio) begin m_cnt = 0; m_fine++; end
            if (m_fine == 4 * (m_period + 1)) begin
               m_fine = 0; m_shadow = m_duty; m_pwm = (m_duty != 0); m_pulse = 1;
            end else if (m_fine == m_shadow) begin
               m_pwm = 0;
            end
         end
         if (wr_en) begin
            case (wr_addr)
               2'd0: m_period = int'(wr_data);
               2'd1: m_duty = (int'(wr_data) << 2) | (m_duty & 3);
               2'd2: m_duty = (m_duty & ~3) | ((int'(wr_data) >> 4) & 3);
               default: m_ps = int'(wr_data) & 3;
            endcase
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         n_cmp++;
         if (pwm_out !== m_pwm || period_pulse !== m_pulse) begin
            n_bad++;
            $display("FAIL %s per-clock: pwm_out=%b period_pulse=%b expected %b %b at %0t",
                     cur_req, pwm_out, period_pulse, m_pwm, m_pulse, $time);
         end
      end
   end

   task automatic chk(input string req, input string what, input int got, input int exp);
      n_cmp++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 2'(a); wr_data = 8'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic set_duty(input int d);
      wr(1, d >> 2);
      wr(2, (d & 3) << 4);
   endtask

   task automatic wait_pulse();
      int g = 0;
      @(negedge clk);
      while (!period_pulse && g < 5000) begin @(negedge clk); g++; end
   endtask

   // assumes the current negedge sample lies in a cycle-start clock
   task automatic count_cycle(output int hi, output int len);
      hi = 0; len = 0;
      do begin
         if (pwm_out) hi++;
         len++;
         @(negedge clk);
      end while (!period_pulse && len < 5000);
   endtask

   task automatic measure(output int hi, output int len);
      wait_pulse();
      count_cycle(hi, len);
   endtask

   task automatic setup(input int per, input int ps, input int d);
      @(negedge clk); enable = 1'b0;
      wr(0, per); wr(3, ps); set_duty(d);
      @(negedge clk); enable = 1'b1;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #(8 * 150000);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      int hi, len, cnt;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      cur_req = "R1";
      chk("R1", "pwm_out after reset", int'(pwm_out), 0);
      chk("R1", "period_pulse after reset", int'(period_pulse), 0);
      enable = 1'b1;
      measure(hi, len);
      chk("R1", "default cycle length", len, 1024);
      chk("R1", "default duty high time", hi, 0);

      cur_req = "R3";
      setup(3, 0, 5);
      measure(hi, len);
      chk("R3", "cycle length period 3 ratio 1", len, 16);
      chk("R4", "high time duty 5 ratio 1", hi, 5);

      cur_req = "R2";
      setup(1, 1, 3);
      measure(hi, len);
      chk("R2", "cycle length ratio 4", len, 32);
      chk("R4", "high time duty 3 ratio 4", hi, 12);
      setup(1, 2, 3);
      measure(hi, len);
      chk("R2", "cycle length code 10", len, 128);
      chk("R4", "high time duty 3 ratio 16", hi, 48);
      setup(1, 3, 5);
      measure(hi, len);
      chk("R2", "cycle length code 11", len, 128);
      chk("R4", "high time duty 5 ratio 16", hi, 80);

      cur_req = "R5";
      setup(3, 0, 0);
      measure(hi, len);
      chk("R5", "high time duty 0", hi, 0);

      cur_req = "R6";
      setup(3, 0, 16);
      measure(hi, len);
      chk("R6", "high time duty equal to cycle", hi, 16);
      set_duty(1023);
      measure(hi, len);
      measure(hi, len);
      chk("R6", "high time duty far beyond cycle", hi, 16);

      cur_req = "R7";
      setup(7, 0, 20);
      wait_pulse();
      fork
         count_cycle(hi, len);
         begin repeat (8) @(negedge clk); set_duty(4); end
      join
      chk("R7", "cycle with mid-cycle write keeps old duty", hi, 20);
      count_cycle(hi, len);
      chk("R7", "next cycle uses new duty", hi, 4);

      cur_req = "R8";
      setup(3, 0, 5);
      wait_pulse();
      cnt = 0;
      for (int i = 0; i < 48; i++) begin
         if (period_pulse) cnt++;
         @(negedge clk);
      end
      chk("R8", "pulses in three cycles", cnt, 3);

      cur_req = "R9";
      wait_pulse();
      repeat (2) @(negedge clk);
      enable = 1'b0;
      cnt = 0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (pwm_out || period_pulse) cnt++;
      end
      chk("R9", "active clocks while disabled", cnt, 0);
      enable = 1'b1;
      cnt = 0;
      for (int i = 0; i < 15; i++) begin
         @(negedge clk);
         if (pwm_out) cnt++;
      end
      chk("R9", "high clocks before first cycle start", cnt, 0);

      cur_req = "R10";
      setup(255, 0, 1);
      measure(hi, len);
      chk("R10", "cycle length period 0xFF", len, 1024);
      chk("R10", "high time duty 1", hi, 1);
      set_duty(1023);
      measure(hi, len);
      measure(hi, len);
      chk("R10", "high time duty 1023", hi, 1023);
      setup(63, 0, 128);
      measure(hi, len);
      chk("R10", "cycle length period 0x3F", len, 256);
      chk("R4", "high time duty 128 period 0x3F", hi, 128);

      repeat (4) @(negedge clk);
      finish_run();
   end

endmodule